// File: doc/BRIEF.md
# Dual-Space External Memory Bus Controller

This block sits between a processor core and a parallel external memory bus. The external memory holds two separate address spaces of up to 1 MB each. The data space can be read and written. The constant/code space can only be read. The controller drives a 20-bit address, made of 16 base lines and 4 extended lines. It also drives an 8-bit data path, split at the pad into an output value, an output enable and an input value. Each space has its own active-low read strobe, and there is one active-low write strobe.

The core raises a request together with a space select, a read/write flag, an address and write data. It also supplies a wait-state setting from 0 to 7, which is sampled when the request is accepted. The core receives the captured read data, a one-cycle done pulse and a one-cycle error pulse. When the core signals that the current cycle goes to internal RAM or ROM, the controller leaves the bus untouched, so the address lines keep their last external value.

An external access has three parts. There is one setup cycle with all strobes high. Then the selected strobe is held low for wait+1 cycles. A write then adds one hold cycle. Read data is taken on the last strobe-low cycle.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is held, all three strobes are high, the data output enable is low, done and error are low, and the external address is zero.
- R2: The external address is loaded only when an external access is accepted. It then stays at that value through the access and afterwards, until the next accepted access.
- R3: A request made while the internal-access input is high starts no bus access. The address stays the same, every strobe stays high and no done pulse occurs.
- R4: A read with space select 0 (data) lowers only the data read strobe. A read with space select 1 (code) lowers only the code read strobe. At most one strobe is ever low.
- R5: After acceptance there is one setup cycle with every strobe high. The selected strobe is then low for exactly W+1 consecutive cycles, where W is the wait setting sampled at acceptance. Later changes to the wait setting do not affect the running access.
- R6: A read captures the input data present on the last strobe-low cycle. The captured value appears on the read data output and holds there until the next read.
- R7: A data-space write holds the write strobe low for W+1 cycles. The output enable is high during those cycles and for one hold cycle after them, W+2 cycles in all. While the enable is high, the data output equals the write data. The enable is low at all other times.
- R8: A write request to code space (select 1, write 1) is rejected. The error output pulses high for one cycle in the cycle after the request edge. No strobe falls, no done pulse occurs and the address is unchanged.
- R9: Done is a single-cycle pulse. With the accepting edge counted as edge 0, done is high in the cycle after edge W+2 for a read and after edge W+3 for a write.
- R10: A request is accepted only when the controller is idle. Requests and address changes made during an access are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request from the core |
| int_acc_i | input | 1 | Current cycle targets internal memory |
| space_i | input | 1 | 0 = data space, 1 = code space |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Access address |
| wdata_i | input | 8 | Write data |
| wait_i | input | 3 | Wait-state count W |
| rdata_o | output | 8 | Captured read data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejected-write pulse |
| ext_addr_o | output | 20 | External address lines |
| ext_dout_o | output | 8 | Data value to the bus pads |
| ext_doe_o | output | 1 | Data pad output enable |
| ext_din_i | input | 8 | Data value from the bus pads |
| rd_data_n_o | output | 1 | Data-space read strobe, active low |
| rd_code_n_o | output | 1 | Code-space read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
The properties assume that the core pulses a request only when it wants an access. They also assume that the core reads done and error as pulses and not as levels. They place no limits on the external data input or on the wait setting. The stimulus keeps the internal-access input and the request together only in the dedicated internal-cycle test. It drops each request in the cycle after its accepting edge, except in the test that deliberately holds the request and changes the address during a busy access. The wait setting is driven to values across the full 0 to 7 range, including a mid-access change.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    localparam int XM_ADDR_W = 20;
    localparam int XM_DATA_W = 8;
    localparam int XM_WS_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } xmem_st_e;
endpackage

// File: rtl/xmem_req_gate.sv
module xmem_req_gate (
    input  logic req_i,
    input  logic int_acc_i,
    input  logic space_i,
    input  logic wr_i,
    input  logic idle_i,
    output logic accept_o,
    output logic reject_o
);
    logic live;
    logic code_wr;

    always_comb begin
        live     = req_i && !int_acc_i && idle_i;
        code_wr  = space_i && wr_i;
        accept_o = live && !code_wr;
        reject_o = live && code_wr;
    end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int WS_W = XM_WS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic            reject_i,
    input  logic            space_i,
    input  logic            wr_i,
    input  logic [WS_W-1:0] wait_i,
    output xmem_st_e        st_o,
    output logic            code_o,
    output logic            wr_o,
    output logic            capture_o,
    output logic            done_o,
    output logic            err_o
);
    typedef struct packed {
        xmem_st_e        st;
        logic [WS_W-1:0] cnt;
        logic            code;
        logic            wr;
        logic            done;
        logic            err;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, cnt: '0, code: 1'b0,
                                 wr: 1'b0, done: 1'b0, err: 1'b0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = reject_i;
        case (seq_q.st)
            ST_IDLE: begin
                if (accept_i) begin
                    seq_d.st   = ST_SETUP;
                    seq_d.code = space_i;
                    seq_d.wr   = wr_i;
                    seq_d.cnt  = wait_i;
                end
            end
            ST_SETUP: seq_d.st = ST_STROBE;
            ST_STROBE: begin
                if (seq_q.cnt == '0) begin
                    if (seq_q.wr) begin
                        seq_d.st = ST_HOLD;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    always_comb begin
        st_o      = seq_q.st;
        code_o    = seq_q.code;
        wr_o      = seq_q.wr;
        done_o    = seq_q.done;
        err_o     = seq_q.err;
        capture_o = (seq_q.st == ST_STROBE) && (seq_q.cnt == '0) && !seq_q.wr;
    end
endmodule

// File: rtl/xmem_pin_drv.sv
module xmem_pin_drv
    import xmem_pkg::*;
#(
    parameter int ADDR_W = XM_ADDR_W,
    parameter int DATA_W = XM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] ext_din_i,
    input  xmem_st_e          st_i,
    input  logic              code_i,
    input  logic              wr_i,
    output logic [ADDR_W-1:0] ext_addr_o,
    output logic [DATA_W-1:0] ext_dout_o,
    output logic              ext_doe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rd_data_n_o,
    output logic              rd_code_n_o,
    output logic              wr_n_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } pins_t;

    pins_t pins_d, pins_q;
    logic  in_strobe;

    always_comb begin
        pins_d = pins_q;
        if (load_i) begin
            pins_d.addr  = addr_i;
            pins_d.wdata = wdata_i;
        end
        if (capture_i) pins_d.rdata = ext_din_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    always_comb begin
        in_strobe   = (st_i == ST_STROBE);
        rd_data_n_o = !(in_strobe && !wr_i && !code_i);
        rd_code_n_o = !(in_strobe && !wr_i && code_i);
        wr_n_o      = !(in_strobe && wr_i);
        ext_doe_o   = wr_i && (in_strobe || (st_i == ST_HOLD));
        ext_addr_o  = pins_q.addr;
        ext_dout_o  = pins_q.wdata;
        rdata_o     = pins_q.rdata;
    end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W = XM_ADDR_W,
    parameter int DATA_W = XM_DATA_W,
    parameter int WS_W   = XM_WS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              int_acc_i,
    input  logic              space_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [WS_W-1:0]   wait_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] ext_addr_o,
    output logic [DATA_W-1:0] ext_dout_o,
    output logic              ext_doe_o,
    input  logic [DATA_W-1:0] ext_din_i,
    output logic              rd_data_n_o,
    output logic              rd_code_n_o,
    output logic              wr_n_o
);
    xmem_st_e st;
    logic     idle;
    logic     accept;
    logic     reject;
    logic     cur_code;
    logic     cur_wr;
    logic     capture;

    assign idle = (st == ST_IDLE);

    xmem_req_gate u_gate (
        .req_i     (req_i),
        .int_acc_i (int_acc_i),
        .space_i   (space_i),
        .wr_i      (wr_i),
        .idle_i    (idle),
        .accept_o  (accept),
        .reject_o  (reject)
    );

    xmem_seq #(.WS_W(WS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .reject_i  (reject),
        .space_i   (space_i),
        .wr_i      (wr_i),
        .wait_i    (wait_i),
        .st_o      (st),
        .code_o    (cur_code),
        .wr_o      (cur_wr),
        .capture_o (capture),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    xmem_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .capture_i   (capture),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .ext_din_i   (ext_din_i),
        .st_i        (st),
        .code_i      (cur_code),
        .wr_i        (cur_wr),
        .ext_addr_o  (ext_addr_o),
        .ext_dout_o  (ext_dout_o),
        .ext_doe_o   (ext_doe_o),
        .rdata_o     (rdata_o),
        .rd_data_n_o (rd_data_n_o),
        .rd_code_n_o (rd_code_n_o),
        .wr_n_o      (wr_n_o)
    );
endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic              err_o,
    input logic [ADDR_W-1:0] ext_addr_o,
    input logic              ext_doe_o,
    input logic              rd_data_n_o,
    input logic              rd_code_n_o,
    input logic              wr_n_o
);
    logic [2:0] low_vec;
    assign low_vec = {~rd_data_n_o, ~rd_code_n_o, ~wr_n_o};

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(low_vec) <= 1);

    p_addr_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (low_vec != 3'b000) |-> $stable(ext_addr_o));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (low_vec == 3'b000) && !ext_doe_o);

    p_wr_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> ext_doe_o);

    p_oe_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_doe_o |-> rd_data_n_o && rd_code_n_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (low_vec == 3'b000) && !ext_doe_o);
endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_o      (done_o),
    .err_o       (err_o),
    .ext_addr_o  (ext_addr_o),
    .ext_doe_o   (ext_doe_o),
    .rd_data_n_o (rd_data_n_o),
    .rd_code_n_o (rd_code_n_o),
    .wr_n_o      (wr_n_o)
);

// File: tb/xmem_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module xmem_bus_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        int_acc_i = 1'b0;
    logic        space_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [19:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [2:0]  wait_i = '0;
    logic [7:0]  ext_din_i = '0;
    logic [7:0]  rdata_o;
    logic        done_o, err_o;
    logic [19:0] ext_addr_o;
    logic [7:0]  ext_dout_o;
    logic        ext_doe_o, rd_data_n_o, rd_code_n_o, wr_n_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xmem_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .int_acc_i(int_acc_i),
        .space_i(space_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .wait_i(wait_i), .rdata_o(rdata_o), .done_o(done_o), .err_o(err_o),
        .ext_addr_o(ext_addr_o), .ext_dout_o(ext_dout_o), .ext_doe_o(ext_doe_o),
        .ext_din_i(ext_din_i), .rd_data_n_o(rd_data_n_o),
        .rd_code_n_o(rd_code_n_o), .wr_n_o(wr_n_o)
    );

    typedef struct packed {
        logic        space;
        logic        wr;
        logic [19:0] addr;
        logic [7:0]  wdata;
        logic [2:0]  ws;
        logic [7:0]  din;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 20'h12345, 8'h00, 3'd0, 8'hA5},
        '{1'b1, 1'b0, 20'hFEDCB, 8'h00, 3'd7, 8'h3C},
        '{1'b0, 1'b1, 20'h80001, 8'h5A, 3'd2, 8'h11},
        '{1'b1, 1'b0, 20'h0FFFF, 8'h00, 3'd3, 8'hC3},
        '{1'b0, 1'b1, 20'hFFFFF, 8'h99, 3'd0, 8'h22},
        '{1'b0, 1'b0, 20'h00000, 8'h00, 3'd5, 8'h7E}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit all_high();
        return rd_data_n_o && rd_code_n_o && wr_n_o;
    endfunction

    task automatic run_vec(input vec_t v);
        int n_done = 0;
        int low_ok = 0, low_bad = 0, oe_cnt = 0, addr_bad = 0, dout_bad = 0;
        bit setup_ok = 1'b0;
        logic own;
        @(negedge clk);
        req_i = 1'b1; int_acc_i = 1'b0; space_i = v.space; wr_i = v.wr;
        addr_i = v.addr; wdata_i = v.wdata; wait_i = v.ws; ext_din_i = v.din;
        @(negedge clk);
        req_i = 1'b0; addr_i = ~v.addr; wait_i = ~v.ws;
        for (int n = 1; n <= 20; n++) begin
            if (n == 1) setup_ok = all_high() && !ext_doe_o;
            if (ext_addr_o != v.addr) addr_bad++;
            own = v.wr ? wr_n_o : (v.space ? rd_code_n_o : rd_data_n_o);
            if (!own) low_ok++;
            if (($countones({~rd_data_n_o, ~rd_code_n_o, ~wr_n_o}) - (own ? 0 : 1)) != 0)
                low_bad++;
            if (ext_doe_o) begin
                oe_cnt++;
                if (ext_dout_o != v.wdata) dout_bad++;
            end
            if (done_o) begin
                n_done = n;
                break;
            end
            @(negedge clk);
        end
        check(setup_ok, "R5 setup cycle strobes high", int'(setup_ok), 1);
        check(low_ok == int'(v.ws) + 1, "R5 strobe low cycles", low_ok, int'(v.ws) + 1);
        check(low_bad == 0, "R4 wrong strobe low", low_bad, 0);
        check(addr_bad == 0, "R2 address held", addr_bad, 0);
        check(n_done == int'(v.ws) + (v.wr ? 4 : 3), "R9 done latency",
              n_done, int'(v.ws) + (v.wr ? 4 : 3));
        if (v.wr) begin
            check(oe_cnt == int'(v.ws) + 2, "R7 enable cycles", oe_cnt, int'(v.ws) + 2);
            check(dout_bad == 0, "R7 write data", dout_bad, 0);
        end else begin
            check(oe_cnt == 0, "R7 no enable on read", oe_cnt, 0);
            check(rdata_o == v.din, "R6 read data", int'(rdata_o), int'(v.din));
        end
        @(negedge clk);
        check(!done_o, "R9 done one cycle", int'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        logic [19:0] hold_a;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(all_high(), "R1 strobes high in reset", int'({rd_data_n_o, rd_code_n_o, wr_n_o}), 7);
        check(!ext_doe_o && !done_o && !err_o, "R1 enable/done/err low",
              int'({ext_doe_o, done_o, err_o}), 0);
        check(ext_addr_o == 20'h0, "R1 address zero", int'(ext_addr_o), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R3 internal cycles leave the bus alone
        hold_a = ext_addr_o;
        seen = 0;
        @(negedge clk);
        req_i = 1'b1; int_acc_i = 1'b1; space_i = 1'b0; wr_i = 1'b0;
        addr_i = 20'h55555; wait_i = 3'd0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (!all_high() || done_o || ext_doe_o || ext_addr_o != hold_a) seen++;
        end
        check(seen == 0, "R3 internal cycle ignored", seen, 0);
        req_i = 1'b0; int_acc_i = 1'b0;

        // R8 code-space write rejected
        seen = 0;
        @(negedge clk);
        req_i = 1'b1; space_i = 1'b1; wr_i = 1'b1; addr_i = 20'h33333; wdata_i = 8'hEE;
        @(negedge clk);
        req_i = 1'b0;
        check(err_o, "R8 error pulse", int'(err_o), 1);
        for (int k = 0; k < 4; k++) begin
            if (!all_high() || done_o || ext_doe_o || ext_addr_o != hold_a) seen++;
            @(negedge clk);
            if (err_o) seen++;
        end
        check(seen == 0, "R8 no bus activity after reject", seen, 0);

        // R10 requests and address changes during an access are ignored
        seen = 0;
        @(negedge clk);
        req_i = 1'b1; space_i = 1'b0; wr_i = 1'b0; addr_i = 20'h11111;
        wait_i = 3'd1; ext_din_i = 8'h6D;
        @(negedge clk);
        addr_i = 20'h22222; wait_i = 3'd7;
        for (int n = 1; n <= 20; n++) begin
            if (ext_addr_o != 20'h11111) seen++;
            if (done_o) begin
                req_i = 1'b0;
                check(n == 4, "R10 busy request ignored, R5 wait sampled once", n, 4);
                break;
            end
            @(negedge clk);
        end
        check(seen == 0, "R10 address held while busy", seen, 0);
        check(rdata_o == 8'h6D, "R6 read data after held request", int'(rdata_o), 8'h6D);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule